// File: doc/BRIEF.md
# IN Endpoint Interrupt Status Aggregator

This block keeps the interrupt status of six device IN endpoints in a full-speed USB device controller. The packet engine sends it single-cycle event pulses for each endpoint: transfer complete, endpoint disabled, timeout, IN token seen while the transmit FIFO was empty, and NAK sampled. Each endpoint also reports how many words its transmit FIFO holds. One global select decides whether "FIFO empty" means at least half free or fully drained.

Software reaches the block over a simple register bus. The bus provides one status word and one mask word per endpoint. The event bits are sticky and are cleared by writing a 1 to them. The FIFO-empty bit follows the FIFO level directly. The NAK-effective bit is cleared only by a separate release strobe from the endpoint control logic.

Each status word is ANDed with its mask and OR-reduced into a one-bit pending flag for that endpoint. The pending flags are registered, and their OR drives the single IN-endpoint interrupt line. Clearing the status bits underneath therefore drops both summary levels without any extra write.

Top module: `inep_irq_hub`

## Requirements
- R1: After reset, every status word reads 0x0000_0080 while its FIFO reports zero words used. Every mask word reads 0, `ep_pending` is 0 and `in_ep_irq` is 0.
- R2: Endpoint n has its status word at byte address 0x908 + 0x20*n and its mask word at 0x90C + 0x20*n, for n = 0..5. Every other address reads 0, and writes to other addresses change nothing.
- R3: A pulse on `ev_xfer_done`, `ev_ep_off`, `ev_timeout` or `ev_tok_empty` for endpoint n sets bit 0, 1, 3 or 4 of that endpoint's status word. The bit stays set until software clears it.
- R4: Writing the status word clears each of bits 0, 1, 3 and 4 where the write data holds a 1. Bits written with 0 keep their value.
- R5: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Status bit 7 is a live read-only flag computed from `fifo_used`, with FIFO depth 16. When `lvl_full_empty` = 0 it is 1 if the FIFO has 8 or fewer words used. When `lvl_full_empty` = 1 it is 1 only if 0 words are used. Writes do not change it.
- R7: Status bit 6 is set by a pulse on `ev_nak_seen` and cleared only by a pulse on `nak_release`. Bus writes do not change it. If both pulses arrive in the same cycle, the bit is set.
- R8: `nak_reply[n]` is 1 exactly when status bit 6 of endpoint n is set and `stall_req[n]` is 0, so a stall request overrides NAK.
- R9: Status bits 2, 5 and 31:8 always read 0. In the mask word only bits 0, 1, 3, 4, 6 and 7 can be written, so a write of all ones reads back as 0x0000_00DB.
- R10: `ep_pending[n]` is a register. One cycle after any change, it equals the OR of endpoint n's status ANDed with its mask. A masked bit still latches and can still be read.
- R11: `in_ep_irq` is the OR of `ep_pending`. Clearing the last unmasked pending status bit drops both `ep_pending[n]` and `in_ep_irq` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_xfer_done | input | 6 | Transfer-complete pulse per endpoint |
| ev_ep_off | input | 6 | Endpoint-disabled pulse per endpoint |
| ev_timeout | input | 6 | Timeout pulse per endpoint |
| ev_tok_empty | input | 6 | IN token with empty FIFO pulse per endpoint |
| ev_nak_seen | input | 6 | NAK sampled pulse per endpoint |
| nak_release | input | 6 | Clear-NAK strobe per endpoint |
| stall_req | input | 6 | Stall request per endpoint |
| fifo_used | input | 30 | Words used in each FIFO, 5 bits per endpoint, endpoint 0 in the low bits |
| lvl_full_empty | input | 1 | 1: empty means fully drained; 0: half free |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| ep_pending | output | 6 | Registered per-endpoint pending flags |
| in_ep_irq | output | 1 | Global IN-endpoint interrupt |
| nak_reply | output | 6 | NAK handshake wanted per endpoint |

## Verification
Several properties are checked on every cycle for each endpoint:
- An event pulse always leaves its bit set on the next cycle.
- A clearing write with no competing event always leaves the bit cleared.
- NAK-effective holds until a release strobe arrives.
- The reserved bits stay zero.
- The pending flag always tracks the masked status one cycle late.
- The global line equals the OR of the pending flags.
- A NAK reply never appears while a stall is requested.

Some behaviour only the bench scenarios can show:
- The address map and the gaps in it read as zero.
- Mask write-back is limited to the implemented bits.
- The FIFO-empty threshold is correct on both sides of each level setting.
- Masked bits still latch while raising no interrupt.

// File: rtl/inep_irq_pkg.sv
package inep_irq_pkg;

  localparam int unsigned WORD_W = 32;

  // bit positions inside a status / mask word
  localparam int unsigned B_XFER = 0;
  localparam int unsigned B_OFF  = 1;
  localparam int unsigned B_TMO  = 3;
  localparam int unsigned B_TOK  = 4;
  localparam int unsigned B_NAK  = 6;
  localparam int unsigned B_TXE  = 7;

  // implemented bits and the subset cleared by writing one
  localparam logic [WORD_W-1:0] IMPL_BITS = 32'h0000_00DB;
  localparam logic [WORD_W-1:0] W1C_BITS  = 32'h0000_001B;

  typedef struct packed {
    logic txe;
    logic nak;
    logic tok;
    logic tmo;
    logic off;
    logic xfer;
  } ep_flags_t;

  function automatic logic [WORD_W-1:0] flags_to_word(input ep_flags_t f);
    logic [WORD_W-1:0] w;
    w         = '0;
    w[B_XFER] = f.xfer;
    w[B_OFF]  = f.off;
    w[B_TMO]  = f.tmo;
    w[B_TOK]  = f.tok;
    w[B_NAK]  = f.nak;
    w[B_TXE]  = f.txe;
    return w;
  endfunction

  function automatic ep_flags_t word_to_flags(input logic [WORD_W-1:0] w);
    ep_flags_t f;
    f.xfer = w[B_XFER];
    f.off  = w[B_OFF];
    f.tmo  = w[B_TMO];
    f.tok  = w[B_TOK];
    f.nak  = w[B_NAK];
    f.txe  = w[B_TXE];
    return f;
  endfunction

  // FIFO empty test: full_sel=1 -> no word used; else free space >= depth/2
  function automatic logic fifo_empty_level(input int unsigned used,
                                            input int unsigned depth,
                                            input logic        full_sel);
    if (full_sel) return (used == 0);
    return (used <= (depth - depth / 2));
  endfunction

  // sticky bit update: clear request first, event set wins
  function automatic logic sticky_next(input logic cur, input logic clr, input logic set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/inep_regdec.sv
module inep_regdec #(
  parameter int unsigned NEP      = 6,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE     = 32'h908,
  parameter int unsigned STRIDE   = 32'h20,
  parameter int unsigned MASK_OFS = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NEP-1:0]    stat_hit,
  output logic [NEP-1:0]    mask_hit,
  output logic [NEP-1:0]    stat_wr,
  output logic [NEP-1:0]    mask_wr
);

  localparam int unsigned SH    = $clog2(STRIDE);
  localparam int unsigned LIMIT = BASE + NEP * STRIDE;
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LIMIT);

  logic              in_range;
  logic [ADDR_W-1:0] ofs;
  logic [SH-1:0]     low;
  logic [ADDR_W-SH-1:0] idx;
  logic              wr_go;

  assign in_range = (bus_addr >= BASE_A) && (bus_addr < LIMIT_A);
  assign ofs      = bus_addr - BASE_A;
  assign low      = ofs[SH-1:0];
  assign idx      = ofs[ADDR_W-1:SH];
  assign wr_go    = bus_sel && bus_we;

  for (genvar i = 0; i < NEP; i++) begin : g_hit
    logic ep_sel;
    assign ep_sel      = in_range && (idx == (ADDR_W-SH)'(i));
    assign stat_hit[i] = ep_sel && (low == SH'(0));
    assign mask_hit[i] = ep_sel && (low == SH'(MASK_OFS));
    assign stat_wr[i]  = wr_go && stat_hit[i];
    assign mask_wr[i]  = wr_go && mask_hit[i];
  end

endmodule

// File: rtl/inep_slot.sv
module inep_slot
  import inep_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned UW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_xfer,
  input  logic              ev_off,
  input  logic              ev_tmo,
  input  logic              ev_tok,
  input  logic              ev_nak,
  input  logic              nak_rel,
  input  logic              stall,
  input  logic [UW-1:0]     used,
  input  logic              full_sel,
  input  logic              stat_wr,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] stat_word,
  output logic [WORD_W-1:0] mask_word,
  output logic              hot,
  output logic              nak_out
);

  ep_flags_t st_q;
  ep_flags_t mask_q;
  ep_flags_t clr_req;
  logic      txe_live;

  assign txe_live = fifo_empty_level(32'(used), DEPTH, full_sel);

  // clear requests from a write-one-to-clear access
  always_comb begin
    clr_req      = word_to_flags(wdata & W1C_BITS);
    if (!stat_wr) clr_req = '0;
    clr_req.nak  = nak_rel;
    clr_req.txe  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q.xfer <= sticky_next(st_q.xfer, clr_req.xfer, ev_xfer);
      st_q.off  <= sticky_next(st_q.off,  clr_req.off,  ev_off);
      st_q.tmo  <= sticky_next(st_q.tmo,  clr_req.tmo,  ev_tmo);
      st_q.tok  <= sticky_next(st_q.tok,  clr_req.tok,  ev_tok);
      st_q.nak  <= sticky_next(st_q.nak,  clr_req.nak,  ev_nak);
      st_q.txe  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= word_to_flags(wdata);
  end

  always_comb begin
    ep_flags_t view;
    view      = st_q;
    view.txe  = txe_live;
    stat_word = flags_to_word(view);
  end

  assign mask_word = flags_to_word(mask_q);
  assign hot       = |(stat_word & mask_word);
  assign nak_out   = st_q.nak && !stall;

endmodule

// File: rtl/inep_sum.sv
module inep_sum #(
  parameter int unsigned NEP = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEP-1:0] hot,
  output logic [NEP-1:0] pending,
  output logic           any
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= hot;
  end

  assign any = |pending;

endmodule

// File: rtl/inep_irq_hub.sv
module inep_irq_hub
  import inep_irq_pkg::*;
#(
  parameter int unsigned NEP    = 6,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned UW     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NEP-1:0]      ev_xfer_done,
  input  logic [NEP-1:0]      ev_ep_off,
  input  logic [NEP-1:0]      ev_timeout,
  input  logic [NEP-1:0]      ev_tok_empty,
  input  logic [NEP-1:0]      ev_nak_seen,
  input  logic [NEP-1:0]      nak_release,
  input  logic [NEP-1:0]      stall_req,
  input  logic [NEP*UW-1:0]   fifo_used,
  input  logic                lvl_full_empty,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic [NEP-1:0]      ep_pending,
  output logic                in_ep_irq,
  output logic [NEP-1:0]      nak_reply
);

  logic [NEP-1:0]        stat_hit;
  logic [NEP-1:0]        mask_hit;
  logic [NEP-1:0]        stat_wr;
  logic [NEP-1:0]        mask_wr;
  logic [NEP-1:0]        hot;
  logic [NEP*WORD_W-1:0] stat_flat;
  logic [NEP*WORD_W-1:0] mask_flat;

  inep_regdec #(.NEP(NEP), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .stat_hit (stat_hit),
    .mask_hit (mask_hit),
    .stat_wr  (stat_wr),
    .mask_wr  (mask_wr)
  );

  for (genvar i = 0; i < NEP; i++) begin : g_ep
    inep_slot #(.DEPTH(DEPTH), .UW(UW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_xfer   (ev_xfer_done[i]),
      .ev_off    (ev_ep_off[i]),
      .ev_tmo    (ev_timeout[i]),
      .ev_tok    (ev_tok_empty[i]),
      .ev_nak    (ev_nak_seen[i]),
      .nak_rel   (nak_release[i]),
      .stall     (stall_req[i]),
      .used      (fifo_used[i*UW +: UW]),
      .full_sel  (lvl_full_empty),
      .stat_wr   (stat_wr[i]),
      .mask_wr   (mask_wr[i]),
      .wdata     (bus_wdata),
      .stat_word (stat_flat[i*WORD_W +: WORD_W]),
      .mask_word (mask_flat[i*WORD_W +: WORD_W]),
      .hot       (hot[i]),
      .nak_out   (nak_reply[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NEP; i++) begin
      if (stat_hit[i]) bus_rdata = stat_flat[i*WORD_W +: WORD_W];
      if (mask_hit[i]) bus_rdata = mask_flat[i*WORD_W +: WORD_W];
    end
  end

  inep_sum #(.NEP(NEP)) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .hot     (hot),
    .pending (ep_pending),
    .any     (in_ep_irq)
  );

endmodule

// File: rtl/inep_irq_chk.sv
module inep_irq_chk #(
  parameter int unsigned NEP = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NEP-1:0]      ev_xfer_done,
  input logic [NEP-1:0]      ev_nak_seen,
  input logic [NEP-1:0]      nak_release,
  input logic [NEP-1:0]      stall_req,
  input logic [NEP-1:0]      stat_wr,
  input logic [31:0]         bus_wdata,
  input logic [NEP*32-1:0]   stat_flat,
  input logic [NEP*32-1:0]   mask_flat,
  input logic [NEP-1:0]      ep_pending,
  input logic                in_ep_irq,
  input logic [NEP-1:0]      nak_reply
);

  AST_GLOBAL_OR: assert property (@(posedge clk) disable iff (!rst_n)
    in_ep_irq == (|ep_pending));  // R11

  for (genvar i = 0; i < NEP; i++) begin : g_chk
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_xfer_done[i] |=> stat_flat[i*32 + 0]);  // R5
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr[i] && bus_wdata[0] && !ev_xfer_done[i]) |=> !stat_flat[i*32 + 0]);  // R4
    AST_NAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_flat[i*32 + 6] && !nak_release[i]) |=> stat_flat[i*32 + 6]);  // R7
    AST_NAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_nak_seen[i] |=> stat_flat[i*32 + 6]);  // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_flat[i*32 + 8 +: 24] == '0) && !stat_flat[i*32 + 2] && !stat_flat[i*32 + 5]);  // R9
    AST_PENDING_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ep_pending[i] == $past(|(stat_flat[i*32 +: 32] & mask_flat[i*32 +: 32])));  // R10
    AST_STALL_OVER_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      nak_reply[i] |-> (!stall_req[i] && stat_flat[i*32 + 6]));  // R8
  end

endmodule

bind inep_irq_hub inep_irq_chk #(.NEP(NEP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_xfer_done (ev_xfer_done),
  .ev_nak_seen  (ev_nak_seen),
  .nak_release  (nak_release),
  .stall_req    (stall_req),
  .stat_wr      (stat_wr),
  .bus_wdata    (bus_wdata),
  .stat_flat    (stat_flat),
  .mask_flat    (mask_flat),
  .ep_pending   (ep_pending),
  .in_ep_irq    (in_ep_irq),
  .nak_reply    (nak_reply)
);

// File: tb/inep_irq_hub_bench.sv
module inep_irq_hub_bench;

  localparam int NEP = 6;
  localparam int UW  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NEP-1:0]   ev_xfer_done = '0, ev_ep_off = '0, ev_timeout = '0;
  logic [NEP-1:0]   ev_tok_empty = '0, ev_nak_seen = '0, nak_release = '0, stall_req = '0;
  logic [NEP*UW-1:0] fifo_used = '0;
  logic             lvl_full_empty = 1'b0;
  logic             bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0]      bus_addr = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NEP-1:0]   ep_pending;
  logic             in_ep_irq;
  logic [NEP-1:0]   nak_reply;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;  // 250 MHz

  inep_irq_hub u_inep_irq_hub (.*);

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h908, 32'h0, 32'h0000_0080, 8'd1},  // R1 status reset
    '{1'b0, 12'h90C, 32'h0, 32'h0000_0000, 8'd1},  // R1 mask reset
    '{1'b0, 12'h9A8, 32'h0, 32'h0000_0080, 8'd2},  // R2 last endpoint
    '{1'b0, 12'h928, 32'h0, 32'h0000_0080, 8'd2},  // R2 endpoint 1
    '{1'b0, 12'h9C8, 32'h0, 32'h0000_0000, 8'd2},  // R2 past the end
    '{1'b0, 12'h910, 32'h0, 32'h0000_0000, 8'd2},  // R2 gap
    '{1'b1, 12'h90C, 32'hFFFF_FFFF, 32'h0, 8'd9},
    '{1'b0, 12'h90C, 32'h0, 32'h0000_00DB, 8'd9},  // R9 mask writable bits
    '{1'b1, 12'h908, 32'hFFFF_FFFF, 32'h0, 8'd9},
    '{1'b0, 12'h908, 32'h0, 32'h0000_0080, 8'd9},  // R9 reserved and read-only bits
    '{1'b1, 12'h92C, 32'h0000_0001, 32'h0, 8'd2},
    '{1'b0, 12'h92C, 32'h0, 32'h0000_0001, 8'd2}   // R2 mask of endpoint 1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", {26'd0, ep_pending}, 32'd0);
    chk("R1 irq", {31'd0, in_ep_irq}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VECS[k].we) wr(VECS[k].addr, VECS[k].data);
      else begin
        rd(VECS[k].addr, r);
        chk($sformatf("R%0d table %0d", VECS[k].req, k), r, VECS[k].exp);
      end
    end

    // R10/R11: ep0 fully unmasked, TX empty set -> pending bit 0 only
    @(negedge clk);
    chk("R10 pending ep0", {26'd0, ep_pending}, 32'h1);
    chk("R11 irq on", {31'd0, in_ep_irq}, 32'h1);
    // R6: ep0 used=9 -> bit7 low; pending drops only after one edge
    fifo_used[0 +: UW] = 5'd9;
    #1 rd(12'h908, r);
    chk("R6 half threshold 9", r, 32'h0);
    @(negedge clk);
    chk("R11 irq off", {26'd0, ep_pending, in_ep_irq} , 32'h0);
    fifo_used[0 +: UW] = 5'd8;
    rd(12'h908, r); chk("R6 half threshold 8", r, 32'h80);
    lvl_full_empty = 1'b1;
    rd(12'h908, r); chk("R6 full select 8", r, 32'h0);
    fifo_used[0 +: UW] = 5'd0;
    rd(12'h908, r); chk("R6 full select 0", r, 32'h80);
    lvl_full_empty = 1'b0;

    // R3: events on ep2
    @(negedge clk); ev_xfer_done[2] = 1'b1;
    @(negedge clk); ev_xfer_done[2] = 1'b0;
    rd(12'h948, r); chk("R3 xfer bit", r, 32'h81);
    @(negedge clk); ev_ep_off[2] = 1'b1; ev_timeout[2] = 1'b1; ev_tok_empty[2] = 1'b1;
    @(negedge clk); ev_ep_off[2] = 1'b0; ev_timeout[2] = 1'b0; ev_tok_empty[2] = 1'b0;
    repeat (3) @(negedge clk);
    rd(12'h948, r); chk("R3 sticky all", r, 32'h9B);
    // R4: clear bits 0 and 3 only, zeros keep
    wr(12'h948, 32'h0000_0009);
    rd(12'h948, r); chk("R4 partial clear", r, 32'h92);
    wr(12'h948, 32'h0000_0000);
    rd(12'h948, r); chk("R4 zero write keeps", r, 32'h92);
    wr(12'h948, 32'h0000_0012);
    rd(12'h948, r); chk("R4 full clear", r, 32'h80);

    // R5: event and clear on same cycle, ep3
    @(negedge clk); ev_xfer_done[3] = 1'b1;
    @(negedge clk); ev_xfer_done[3] = 1'b0;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 12'h968; bus_wdata = 32'h1; ev_xfer_done[3] = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; ev_xfer_done[3] = 1'b0;
    rd(12'h968, r); chk("R5 set wins", r, 32'h81);

    // R7/R8: NAK on ep4
    @(negedge clk); ev_nak_seen[4] = 1'b1;
    @(negedge clk); ev_nak_seen[4] = 1'b0;
    rd(12'h988, r); chk("R7 nak set", r, 32'hC0);
    chk("R8 nak reply", {26'd0, nak_reply}, 32'h10);
    stall_req[4] = 1'b1;
    #1 chk("R8 stall overrides", {26'd0, nak_reply}, 32'h0);
    stall_req[4] = 1'b0;
    wr(12'h988, 32'hFFFF_FFFF);
    rd(12'h988, r); chk("R7 write ignored", r, 32'hC0);
    @(negedge clk); ev_nak_seen[4] = 1'b1; nak_release[4] = 1'b1;
    @(negedge clk); ev_nak_seen[4] = 1'b0; nak_release[4] = 1'b0;
    rd(12'h988, r); chk("R7 set wins over release", r, 32'hC0);
    @(negedge clk); nak_release[4] = 1'b1;
    @(negedge clk); nak_release[4] = 1'b0;
    rd(12'h988, r); chk("R7 release clears", r, 32'h80);

    // R10: ep1 mask = bit0 only; masked tok bit latches without pending
    @(negedge clk); ev_tok_empty[1] = 1'b1;
    @(negedge clk); ev_tok_empty[1] = 1'b0;
    @(negedge clk);
    rd(12'h928, r); chk("R10 masked bit latches", r, 32'h90);
    chk("R10 masked no pending", {26'd0, ep_pending}, 32'h1);
    @(negedge clk); ev_xfer_done[1] = 1'b1;
    @(negedge clk); ev_xfer_done[1] = 1'b0;
    chk("R10 pending lags one cycle", {26'd0, ep_pending}, 32'h1);
    @(negedge clk);
    chk("R10 pending ep1", {26'd0, ep_pending}, 32'h3);
    wr(12'h928, 32'h1);
    chk("R11 pending still registered", {26'd0, ep_pending}, 32'h3);
    @(negedge clk);
    chk("R11 leaf clear drops summary", {26'd0, ep_pending}, 32'h1);
    fifo_used[0 +: UW] = 5'd16;
    repeat (2) @(negedge clk);
    chk("R11 irq drops", {31'd0, in_ep_irq}, 32'h0);

    finish_run();
  end

endmodule